// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block is a programmable source of periodic interrupts. A down-counting count register steps once per prescaler tick. The prescaler divides the clock by a stored scale value plus one. When a tick finds the count at zero, the count is refilled from a separate period register, and a one-cycle interrupt pulse is produced. Software sets the count, the scale and the period through plain write strobes. A single enable starts and freezes the whole timer.

In steady state the interrupts are spaced (period + 1) x (scale + 1) clock cycles apart. A period of zero gives an interrupt on every prescaler tick. A scale of zero gives a prescaler tick on every enabled cycle. Interrupt masking and address decoding belong to the surrounding logic.

Top module: `tick_timer`

## Requirements
- R1: After reset the count (`cntOut`) and the prescaler (`preOut`) read 0, the stored scale and period are 0, and `irq` is low.
- R2: While `enable` is high, a nonzero prescaler decrements by one per cycle. A zero prescaler makes a tick and reloads the stored scale value, so a tick occurs every scale+1 enabled cycles. With a scale of 0 there is a tick on every enabled cycle.
- R3: On a tick with a nonzero count, the count decrements by one and `irq` stays low.
- R4: On a tick with a zero count, the count loads the stored period. `irq` is high for exactly the cycle in which `cntOut` first shows the reloaded value. In that cycle `preOut` equals the stored scale.
- R5: With constant settings, consecutive `irq` pulses are exactly (period+1)*(scale+1) cycles apart. A period of 0 gives a pulse on every tick.
- R6: While `enable` is low, the count and the prescaler hold their values and `irq` stays low, unless the count is written.
- R7: A count write (`cntWe`) loads `cntWdata` into the count at the next edge, whatever the state of `enable`. It overrides a decrement or a reload due at the same edge, and no `irq` is raised for that edge.
- R8: A scale write changes only the stored scale. The running prescaler continues from its current value and uses the new scale at its next reload.
- R9: A period write takes effect at the next reload. A reload at the same edge as the write uses the previous period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable for prescaler and count |
| cntWe | input | 1 | Count write strobe |
| cntWdata | input | CNT_W (16) | Count write value |
| sclWe | input | 1 | Scale write strobe |
| sclWdata | input | SCL_W (8) | Scale write value (divide ratio minus one) |
| perWe | input | 1 | Period write strobe |
| perWdata | input | CNT_W (16) | Period write value |
| cntOut | output | CNT_W (16) | Current count |
| preOut | output | SCL_W (8) | Current prescaler value |
| irq | output | 1 | One-cycle interrupt pulse on reload |

## Verification
The bench forces two collisions. First, a software count write lands on the same edge as a due reload: the timer is enabled with a zero count and a zero prescaler while `cntWe` is high. The written value must appear and `irq` must stay low. Second, a period write lands on a reload edge. The count must take the old period, and the new one must show up only at the following reload. A sweep over small scale and period values checks the spacing of the pulses and the reloaded count and prescaler values arithmetically.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Strobes from the control to the count datapath; at most one is acted on.
  typedef struct packed {
    logic loadCnt;    // software write of the count
    logic reloadCnt;  // tick with zero count: refill from period
    logic decCnt;     // tick with nonzero count: step down
  } cntCtrlT;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cntWe,
  input  logic             cntZero,
  input  logic [SCL_W-1:0] scaleVal,
  output cntCtrlT          strb,
  output logic [SCL_W-1:0] preOut,
  output logic             irq
);

  logic [SCL_W-1:0] preQ;
  logic             preZero;
  logic             tickNow;
  logic             irqQ;

  assign preZero = (preQ == '0);
  assign tickNow = enable & preZero;

  // A software count write wins over whatever the tick would do.
  always_comb begin
    strb.loadCnt   = cntWe;
    strb.reloadCnt = tickNow & cntZero & ~cntWe;
    strb.decCnt    = tickNow & ~cntZero & ~cntWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
      irqQ <= 1'b0;
    end else begin
      if (enable) begin
        preQ <= preZero ? scaleVal : preQ - 1'b1;
      end
      irqQ <= strb.reloadCnt;
    end
  end

  assign preOut = preQ;
  assign irq    = irqQ;

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrlT          strb,
  input  logic [CNT_W-1:0] cntWdata,
  input  logic             sclWe,
  input  logic [SCL_W-1:0] sclWdata,
  input  logic             perWe,
  input  logic [CNT_W-1:0] perWdata,
  output logic [CNT_W-1:0] cntOut,
  output logic [SCL_W-1:0] scaleVal,
  output logic             cntZero
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] perQ;
  logic [SCL_W-1:0] sclQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.loadCnt) begin
      cntQ <= cntWdata;
    end else if (strb.reloadCnt) begin
      cntQ <= perQ;
    end else if (strb.decCnt) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perQ <= '0;
      sclQ <= '0;
    end else begin
      if (perWe) perQ <= perWdata;
      if (sclWe) sclQ <= sclWdata;
    end
  end

  assign cntOut   = cntQ;
  assign scaleVal = sclQ;
  assign cntZero  = (cntQ == '0);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cntWe,
  input  logic [CNT_W-1:0] cntWdata,
  input  logic             sclWe,
  input  logic [SCL_W-1:0] sclWdata,
  input  logic             perWe,
  input  logic [CNT_W-1:0] perWdata,
  output logic [CNT_W-1:0] cntOut,
  output logic [SCL_W-1:0] preOut,
  output logic             irq
);

  cntCtrlT          strb;
  logic             cntZero;
  logic [SCL_W-1:0] scaleVal;

  tick_timer_ctrl #(.SCL_W(SCL_W)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cntWe(cntWe),
    .cntZero(cntZero), .scaleVal(scaleVal), .strb(strb),
    .preOut(preOut), .irq(irq)
  );

  tick_timer_dp #(.CNT_W(CNT_W), .SCL_W(SCL_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntWdata(cntWdata),
    .sclWe(sclWe), .sclWdata(sclWdata), .perWe(perWe),
    .perWdata(perWdata), .cntOut(cntOut), .scaleVal(scaleVal),
    .cntZero(cntZero)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 16,
  parameter int SCL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             cntWe,
  input logic [CNT_W-1:0] cntWdata,
  input logic [CNT_W-1:0] cntOut,
  input logic [SCL_W-1:0] preOut,
  input logic             irq
);

  // R2
  pre_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && preOut != '0) |=> preOut == $past(preOut) - 1'b1);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !cntWe && preOut == '0 && cntOut != '0)
      |=> (cntOut == $past(cntOut) - 1'b1) && !irq);

  // R4
  reload_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(cntOut) == '0) && ($past(preOut) == '0) && !$past(cntWe));

  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cntWe) |=> $stable(cntOut) && $stable(preOut) && !irq);

  // R7
  sw_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |=> (cntOut == $past(cntWdata)) && !irq);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .SCL_W(SCL_W)) chk (.*);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

  localparam int CNT_W = 16;
  localparam int SCL_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             cntWe = 1'b0;
  logic [CNT_W-1:0] cntWdata = '0;
  logic             sclWe = 1'b0;
  logic [SCL_W-1:0] sclWdata = '0;
  logic             perWe = 1'b0;
  logic [CNT_W-1:0] perWdata = '0;
  logic [CNT_W-1:0] cntOut;
  logic [SCL_W-1:0] preOut;
  logic             irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W), .SCL_W(SCL_W)) uut (.*);

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Advance one edge; drive and sample 2 ns after it.
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int hCnt;
    int hPre;
    repeat (3) cyc();
    check("R1 count", cntOut, 0);
    check("R1 prescaler", preOut, 0);
    check("R1 irq", irq, 0);
    rstN = 1'b1;
    cyc();

    // R3 / R1: step down from 3 with scale 0, then reload of period 0
    cntWe = 1'b1; cntWdata = 16'd3;
    cyc();
    cntWe = 1'b0;
    check("R7 write while off", cntOut, 3);
    enable = 1'b1;
    cyc(); check("R3 step", cntOut, 2); check("R3 irq low", irq, 0);
    cyc(); check("R3 step", cntOut, 1);
    cyc(); check("R3 step", cntOut, 0);
    cyc(); check("R1 period reset 0 reload", cntOut, 0); check("R4 irq", irq, 1);
    enable = 1'b0;

    // R6: freeze mid-run
    sclWe = 1'b1; sclWdata = 8'd3; cntWe = 1'b1; cntWdata = 16'd40;
    cyc();
    sclWe = 1'b0; cntWe = 1'b0; enable = 1'b1;
    repeat (3) cyc();
    enable = 1'b0;
    cyc();
    hCnt = cntOut; hPre = preOut;
    for (int i = 0; i < 5; i++) begin
      cyc();
      check("R6 count hold", cntOut, hCnt);
      check("R6 pre hold", preOut, hPre);
      check("R6 irq low", irq, 0);
    end

    // R7: count write collides with a due reload
    sclWe = 1'b1; sclWdata = 8'd0; cntWe = 1'b1; cntWdata = 16'd1000;
    cyc();
    sclWe = 1'b0; cntWe = 1'b0; enable = 1'b1;
    for (int i = 0; i < 10 && preOut != 0; i++) cyc();
    enable = 1'b0;
    check("R2 pre drained", preOut, 0);
    cntWe = 1'b1; cntWdata = 16'd0;
    cyc();
    enable = 1'b1; cntWe = 1'b1; cntWdata = 16'd9;
    cyc();
    cntWe = 1'b0;
    check("R7 write wins", cntOut, 9);
    check("R7 no irq", irq, 0);
    cyc();
    check("R7 then step", cntOut, 8);
    enable = 1'b0;

    // R9: period write on a reload edge
    perWe = 1'b1; perWdata = 16'd7; cntWe = 1'b1; cntWdata = 16'd0;
    cyc();
    cntWe = 1'b0; perWdata = 16'd2; enable = 1'b1;
    cyc();
    perWe = 1'b0;
    check("R9 old period used", cntOut, 7);
    check("R9 irq", irq, 1);
    repeat (7) cyc();
    check("R9 run down", cntOut, 0);
    cyc();
    check("R9 new period used", cntOut, 2);
    check("R9 irq", irq, 1);
    enable = 1'b0;

    // R8: scale write while prescaler runs
    sclWe = 1'b1; sclWdata = 8'd3;
    cyc();
    sclWe = 1'b0; enable = 1'b1;
    for (int i = 0; i < 10 && preOut != 3; i++) cyc();
    check("R2 reload to scale", preOut, 3);
    sclWe = 1'b1; sclWdata = 8'd1;
    cyc();
    sclWe = 1'b0;
    check("R8 keep running", preOut, 2);
    cyc(); check("R8 keep running", preOut, 1);
    cyc(); check("R8 keep running", preOut, 0);
    cyc(); check("R8 new scale", preOut, 1);
    enable = 1'b0;

    // R2 / R4 / R5 sweep over small scale and period values
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 5; p++) begin
        int gap;
        enable = 1'b0;
        sclWe = 1'b1; sclWdata = SCL_W'(s);
        perWe = 1'b1; perWdata = CNT_W'(p);
        cntWe = 1'b1; cntWdata = '0;
        cyc();
        sclWe = 1'b0; perWe = 1'b0; cntWe = 1'b0;
        enable = 1'b1;
        for (int i = 0; i < 300 && !irq; i++) cyc();
        check("R4 first irq seen", irq, 1);
        check("R4 reload value", cntOut, p);
        check("R2 pre at reload", preOut, s);
        for (int k = 0; k < 2; k++) begin
          gap = 0;
          do begin
            cyc();
            gap++;
          end while (!irq && gap < 300);
          check("R5 irq spacing", gap, (p + 1) * (s + 1));
          check("R4 reload value", cntOut, p);
        end
      end
    end
    enable = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule